// File: doc/BRIEF.md
# Indexed MPU Region Register Bank

This block holds the programmable region descriptors of a memory protection unit. Each region has three 32-bit words: a base address, a size word and an access-control word. Software does not address the regions directly. It first writes a region-number index register. It then reads or writes the base, size or access-control register, and that access lands in the entry chosen by the current index. Accesses arrive on a coprocessor-style interface. Each access carries four coordinate fields (primary register, first opcode, secondary register, second opcode), a privilege flag, a write flag and 32 bits of data.

The block answers a read one cycle after the access strobe. It stores a write on the edge of the strobe. Every write to a region word raises a one-cycle flush request, so that translation caches downstream drop mappings that may now be stale. An unprivileged access is rejected with an undefined-access flag, and so is an access whose coordinates match none of the four registers. The number of regions is a parameter. A build with zero regions keeps its register decode but holds no storage.

Top module: `mpu_region_bank`

## Requirements
- R1: The four registers are selected by the coordinates below. All other coordinates match nothing.
  - Base word: primary register 6, first opcode 0, secondary register 1, second opcode 0.
  - Size word: the same, with second opcode 2.
  - Access-control word: the same, with second opcode 4.
  - Region index: primary register 6, first opcode 0, secondary register 2, second opcode 0.
  The three region words are stored independently of each other.
- R2: The current index selects the entry of all three region arrays, for reads and for writes.
- R3: A write of a value greater than or equal to NUM_REGIONS to the index register is dropped and the old index is kept. A smaller value is taken.
- R4: The index register is zero after reset, and a read of it returns its current value, zero-extended.
- R5: A privileged write to a base, size or access-control word asserts flush_req for exactly the one cycle after the strobe. Reads, index writes and rejected accesses never assert it.
- R6: After reset, every entry of all three arrays reads as zero.
- R7: With NUM_REGIONS = 0, reads of the three region words return zero with rd_valid set, and writes to them store nothing and raise no flush.
- R8: An access with acc_priv low raises undef_acc in the next cycle. It changes no state, and the cycle carries rd_data = 0 and rd_valid = 0.
- R9: A strobed access whose coordinates match no register raises undef_acc in the next cycle. It changes no state and raises no flush.
- R10: An accepted read drives rd_valid and rd_data in the cycle after its strobe. A read strobed in the cycle right after a write returns the newly written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access strobe, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_priv | input | 1 | 1 = privileged requester |
| acc_crn | input | CRN_W | Primary register coordinate |
| acc_opc1 | input | OPC1_W | First opcode coordinate |
| acc_crm | input | CRM_W | Secondary register coordinate |
| acc_opc2 | input | OPC2_W | Second opcode coordinate |
| acc_wdata | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data, valid one cycle after the strobe |
| rd_valid | output | 1 | Read data qualifier |
| undef_acc | output | 1 | Rejected access, one cycle after the strobe |
| flush_req | output | 1 | Translation flush pulse after a region word write |

## Verification
The block can do two things in the same cycle. It can raise the flush pulse for a region write while it accepts the read strobe of the next access. The bench provokes this by issuing a base-word write and then, in the very next cycle, a read of the same word. It then judges two sampled cycles: flush_req must be high in the cycle that carries the read strobe, and one cycle later rd_data must already show the new value with rd_valid set. A companion build with zero regions receives the same access stream. On it, the bench checks that the identical writes leave reads at zero and never raise a flush.

// File: rtl/mpu_bank_pkg.sv
package mpu_bank_pkg;

  typedef enum logic [2:0] {
    SEL_NONE   = 3'd0,
    SEL_BASE   = 3'd1,
    SEL_SIZE   = 3'd2,
    SEL_ACCESS = 3'd3,
    SEL_INDEX  = 3'd4
  } reg_sel_e;

  localparam int unsigned N_ARRAYS = 3;

  // coordinate encodings decoded by the bank
  localparam int unsigned ENC_CRN        = 6;
  localparam int unsigned ENC_OPC1       = 0;
  localparam int unsigned ENC_CRM_REGION = 1;
  localparam int unsigned ENC_CRM_INDEX  = 2;
  localparam int unsigned ENC_OPC2_BASE  = 0;
  localparam int unsigned ENC_OPC2_SIZE  = 2;
  localparam int unsigned ENC_OPC2_ACC   = 4;
  localparam int unsigned ENC_OPC2_INDEX = 0;

endpackage

// File: rtl/mpu_bank_decode.sv
module mpu_bank_decode
  import mpu_bank_pkg::*;
#(
  parameter int unsigned CRN_W  = 4,
  parameter int unsigned OPC1_W = 3,
  parameter int unsigned CRM_W  = 4,
  parameter int unsigned OPC2_W = 3
) (
  input  logic [CRN_W-1:0]  crn,
  input  logic [OPC1_W-1:0] opc1,
  input  logic [CRM_W-1:0]  crm,
  input  logic [OPC2_W-1:0] opc2,
  output reg_sel_e          sel
);

  logic group_hit;
  assign group_hit = (crn == CRN_W'(ENC_CRN)) && (opc1 == OPC1_W'(ENC_OPC1));

  // R1: fixed coordinate map
  always_comb begin
    sel = SEL_NONE;
    if (group_hit) begin
      if (crm == CRM_W'(ENC_CRM_REGION)) begin
        if (opc2 == OPC2_W'(ENC_OPC2_BASE))      sel = SEL_BASE;
        else if (opc2 == OPC2_W'(ENC_OPC2_SIZE)) sel = SEL_SIZE;
        else if (opc2 == OPC2_W'(ENC_OPC2_ACC))  sel = SEL_ACCESS;
      end else if (crm == CRM_W'(ENC_CRM_INDEX)) begin
        if (opc2 == OPC2_W'(ENC_OPC2_INDEX))     sel = SEL_INDEX;
      end
    end
  end

endmodule

// File: rtl/mpu_region_index.sv
module mpu_region_index #(
  parameter int unsigned NUM_REGIONS = 8,
  parameter int unsigned IDX_W       = 3,
  parameter int unsigned DATA_W      = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [IDX_W-1:0]  idx_q
);

  localparam logic [DATA_W-1:0] LIMIT = DATA_W'(NUM_REGIONS);

  logic in_range;
  assign in_range = (wdata < LIMIT);

  always_ff @(posedge clk) begin
    if (rst)                     idx_q <= '0;
    else if (wr_en && in_range)  idx_q <= wdata[IDX_W-1:0];
  end

  AST_IDX_DROP_OOR: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wdata >= LIMIT)) |=> $stable(idx_q)); // R3

  AST_IDX_TAKE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wdata < LIMIT)) |=> (idx_q == $past(wdata[IDX_W-1:0]))); // R3

endmodule

// File: rtl/mpu_region_array.sv
module mpu_region_array #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned IDX_W  = 3,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_word
);

  // storage without reset so it maps onto block RAM
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] mem_q;
  // per-entry written flags carry the reset-to-zero behaviour
  logic [DEPTH-1:0]  written_q;
  logic              hit_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[idx] <= wdata;
    if (rd_en) mem_q    <= mem[idx];
  end

  always_ff @(posedge clk) begin
    if (rst)        written_q      <= '0;
    else if (wr_en) written_q[idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)        hit_q <= 1'b0;
    else if (rd_en) hit_q <= written_q[idx];
  end

  assign rd_word = hit_q ? mem_q : '0;

  AST_ARR_MARKED: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> written_q[$past(idx)]); // R2

  AST_ARR_CLEARED: assert property (@(posedge clk)
    $past(rst) |-> (written_q == '0)); // R6

endmodule

// File: rtl/mpu_region_bank.sv
module mpu_region_bank
  import mpu_bank_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 8,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned CRN_W       = 4,
  parameter int unsigned OPC1_W      = 3,
  parameter int unsigned CRM_W       = 4,
  parameter int unsigned OPC2_W      = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic              acc_priv,
  input  logic [CRN_W-1:0]  acc_crn,
  input  logic [OPC1_W-1:0] acc_opc1,
  input  logic [CRM_W-1:0]  acc_crm,
  input  logic [OPC2_W-1:0] acc_opc2,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              undef_acc,
  output logic              flush_req
);

  localparam int unsigned IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;
  localparam int unsigned DEPTH = (NUM_REGIONS > 0) ? NUM_REGIONS : 1;
  localparam reg_sel_e ARR_SEL [N_ARRAYS] = '{SEL_BASE, SEL_SIZE, SEL_ACCESS};

  reg_sel_e          sel;
  reg_sel_e          sel_q;
  logic              acc_ok;
  logic              acc_bad;
  logic              rd_ok;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] idx_rd_q;
  logic [N_ARRAYS-1:0] arr_wr;
  logic [DATA_W-1:0] arr_rd [N_ARRAYS];
  logic              rd_valid_q;
  logic              undef_q;
  logic              flush_q;

  mpu_bank_decode #(
    .CRN_W (CRN_W),
    .OPC1_W(OPC1_W),
    .CRM_W (CRM_W),
    .OPC2_W(OPC2_W)
  ) decode_i (
    .crn (acc_crn),
    .opc1(acc_opc1),
    .crm (acc_crm),
    .opc2(acc_opc2),
    .sel (sel)
  );

  // R8, R9: gate every state change on privilege and a decode hit
  assign acc_ok  = acc_valid && acc_priv && (sel != SEL_NONE);
  assign acc_bad = acc_valid && (!acc_priv || (sel == SEL_NONE));
  assign rd_ok   = acc_ok && !acc_write;

  mpu_region_index #(
    .NUM_REGIONS(NUM_REGIONS),
    .IDX_W      (IDX_W),
    .DATA_W     (DATA_W)
  ) index_i (
    .clk  (clk),
    .rst  (rst),
    .wr_en(acc_ok && acc_write && (sel == SEL_INDEX)),
    .wdata(acc_wdata),
    .idx_q(idx)
  );

  generate
    if (NUM_REGIONS > 0) begin : g_store
      for (genvar g = 0; g < N_ARRAYS; g++) begin : g_arr
        assign arr_wr[g] = acc_ok && acc_write && (sel == ARR_SEL[g]);
        mpu_region_array #(
          .DEPTH (DEPTH),
          .IDX_W (IDX_W),
          .DATA_W(DATA_W)
        ) array_i (
          .clk    (clk),
          .rst    (rst),
          .wr_en  (arr_wr[g]),
          .rd_en  (rd_ok && (sel == ARR_SEL[g])),
          .idx    (idx),
          .wdata  (acc_wdata),
          .rd_word(arr_rd[g])
        );
      end
    end else begin : g_empty
      // R7: no storage, reads zero, writes vanish
      assign arr_wr = '0;
      for (genvar g = 0; g < N_ARRAYS; g++) begin : g_zero
        assign arr_rd[g] = '0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q      <= SEL_NONE;
      rd_valid_q <= 1'b0;
      undef_q    <= 1'b0;
      flush_q    <= 1'b0;
      idx_rd_q   <= '0;
    end else begin
      sel_q      <= rd_ok ? sel : SEL_NONE;
      rd_valid_q <= rd_ok;
      undef_q    <= acc_bad;
      flush_q    <= |arr_wr;
      idx_rd_q   <= DATA_W'(idx);
    end
  end

  always_comb begin
    unique case (sel_q)
      SEL_BASE:   rd_data = arr_rd[0];
      SEL_SIZE:   rd_data = arr_rd[1];
      SEL_ACCESS: rd_data = arr_rd[2];
      SEL_INDEX:  rd_data = idx_rd_q;
      default:    rd_data = '0;
    endcase
  end

  assign rd_valid  = rd_valid_q;
  assign undef_acc = undef_q;
  assign flush_req = flush_q;

  AST_UNPRIV_REJECT: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_priv) |=> (undef_acc && !rd_valid && (rd_data == '0) && !flush_req)); // R8

  AST_NO_FLUSH_ON_READ: assert property (@(posedge clk) disable iff (rst)
    (!acc_valid || !acc_write) |=> !flush_req); // R5

  AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_write) |=> (rd_valid != undef_acc)); // R10

  AST_ZERO_RGN_NO_FLUSH: assert property (@(posedge clk) disable iff (rst)
    (NUM_REGIONS == 0) |-> !flush_req); // R7

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!rd_valid && !undef_acc && !flush_req)); // R4

endmodule

// File: tb/mpu_region_bank_tb.sv
module mpu_region_bank_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NREG = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic        acc_priv = 1'b1;
  logic [3:0]  acc_crn = '0;
  logic [2:0]  acc_opc1 = '0;
  logic [3:0]  acc_crm = '0;
  logic [2:0]  acc_opc2 = '0;
  logic [31:0] acc_wdata = '0;

  logic [31:0] rd_data, z_rd_data;
  logic        rd_valid, undef_acc, flush_req;
  logic        z_rd_valid, z_undef_acc, z_flush_req;

  logic [31:0] s_rd, s_zrd;
  logic        s_rdv, s_undef, s_flush, s_zrdv, s_zflush;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mpu_region_bank #(.NUM_REGIONS(NREG)) dut_i (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_priv(acc_priv), .acc_crn(acc_crn), .acc_opc1(acc_opc1),
    .acc_crm(acc_crm), .acc_opc2(acc_opc2), .acc_wdata(acc_wdata),
    .rd_data(rd_data), .rd_valid(rd_valid), .undef_acc(undef_acc),
    .flush_req(flush_req));

  mpu_region_bank #(.NUM_REGIONS(0)) dut_z_i (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_priv(acc_priv), .acc_crn(acc_crn), .acc_opc1(acc_opc1),
    .acc_crm(acc_crm), .acc_opc2(acc_opc2), .acc_wdata(acc_wdata),
    .rd_data(z_rd_data), .rd_valid(z_rd_valid), .undef_acc(z_undef_acc),
    .flush_req(z_flush_req));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  // one strobed cycle; samples the registered outputs at the next falling edge
  task automatic acc(input bit wr, input bit pv, input int crn, input int o1,
                     input int crm, input int o2, input logic [31:0] d);
    acc_valid = 1'b1; acc_write = wr; acc_priv = pv;
    acc_crn = 4'(crn); acc_opc1 = 3'(o1); acc_crm = 4'(crm); acc_opc2 = 3'(o2);
    acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0;
    s_rd = rd_data; s_rdv = rd_valid; s_undef = undef_acc; s_flush = flush_req;
    s_zrd = z_rd_data; s_zrdv = z_rd_valid; s_zflush = z_flush_req;
  endtask

  // register shorthands: 0 base, 1 size, 2 access control, 3 index
  task automatic wr_reg(input int r, input logic [31:0] d);
    if (r == 3) acc(1, 1, 6, 0, 2, 0, d);
    else        acc(1, 1, 6, 0, 1, 2 * r, d);
  endtask

  task automatic rd_reg(input int r);
    if (r == 3) acc(0, 1, 6, 0, 2, 0, '0);
    else        acc(0, 1, 6, 0, 1, 2 * r, '0);
  endtask

  task automatic idle();
    @(negedge clk);
    s_flush = flush_req; s_undef = undef_acc; s_rdv = rd_valid;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset_state();
    chk("R4 rd_valid after reset", 32'(rd_valid), 0);
    chk("R4 undef after reset", 32'(undef_acc), 0);
    chk("R5 flush after reset", 32'(flush_req), 0);
    rd_reg(3);
    chk("R4 index reset value", s_rd, 0);
    chk("R10 index read valid", 32'(s_rdv), 1);
    for (int r = 0; r < NREG; r++) begin
      wr_reg(3, r);
      for (int k = 0; k < 3; k++) begin
        rd_reg(k);
        chk("R6 entry zero after reset", s_rd, 0);
      end
    end
    wr_reg(3, 0);
  endtask

  task automatic t_region_words();
    wr_reg(0, 32'h1000_0000);
    chk("R5 flush after base write", 32'(s_flush), 1);
    wr_reg(1, 32'h0000_0023);
    chk("R5 flush after size write", 32'(s_flush), 1);
    wr_reg(2, 32'h0000_0305);
    chk("R5 flush after access write", 32'(s_flush), 1);
    idle();
    chk("R5 flush lasts one cycle", 32'(s_flush), 0);
    rd_reg(0); chk("R1 base readback", s_rd, 32'h1000_0000);
    chk("R5 no flush on read", 32'(s_flush), 0);
    rd_reg(1); chk("R1 size readback", s_rd, 32'h0000_0023);
    rd_reg(2); chk("R1 access readback", s_rd, 32'h0000_0305);
  endtask

  task automatic t_index_select();
    wr_reg(3, 2);
    chk("R5 no flush on index write", 32'(s_flush), 0);
    rd_reg(3); chk("R4 index readback", s_rd, 2);
    wr_reg(0, 32'h2222_0000);
    wr_reg(2, 32'h0000_0606);
    rd_reg(0); chk("R2 base of region 2", s_rd, 32'h2222_0000);
    rd_reg(1); chk("R2 size of region 2 untouched", s_rd, 0);
    wr_reg(3, 0);
    rd_reg(0); chk("R2 base of region 0 kept", s_rd, 32'h1000_0000);
    rd_reg(2); chk("R2 access of region 0 kept", s_rd, 32'h0000_0305);
  endtask

  task automatic t_index_bounds();
    wr_reg(3, NREG);
    rd_reg(3); chk("R3 index write at count dropped", s_rd, 0);
    wr_reg(3, 32'hFFFF_FFFF);
    rd_reg(3); chk("R3 huge index write dropped", s_rd, 0);
    wr_reg(3, NREG - 1);
    rd_reg(3); chk("R3 last legal index taken", s_rd, NREG - 1);
    wr_reg(3, 0);
  endtask

  task automatic t_unpriv();
    acc(1, 0, 6, 0, 1, 0, 32'hDEAD_BEEF);
    chk("R8 unpriv write undef", 32'(s_undef), 1);
    chk("R8 unpriv write no flush", 32'(s_flush), 0);
    acc(0, 0, 6, 0, 1, 0, '0);
    chk("R8 unpriv read undef", 32'(s_undef), 1);
    chk("R8 unpriv read zero data", s_rd, 0);
    chk("R8 unpriv read not valid", 32'(s_rdv), 0);
    acc(1, 0, 6, 0, 2, 0, 1);
    rd_reg(3); chk("R8 unpriv index write ignored", s_rd, 0);
    rd_reg(0); chk("R8 base unchanged", s_rd, 32'h1000_0000);
    chk("R8 privileged read not undef", 32'(s_undef), 0);
  endtask

  task automatic t_unmatched();
    acc(1, 1, 7, 0, 1, 0, 32'hBAD0_0001);
    chk("R9 wrong crn undef", 32'(s_undef), 1);
    chk("R9 wrong crn no flush", 32'(s_flush), 0);
    acc(1, 1, 6, 0, 1, 1, 32'hBAD0_0002);
    chk("R9 odd opc2 undef", 32'(s_undef), 1);
    acc(1, 1, 6, 1, 1, 0, 32'hBAD0_0003);
    chk("R9 wrong opc1 undef", 32'(s_undef), 1);
    acc(1, 1, 6, 0, 2, 2, 32'h1);
    chk("R9 index crm other opc2 undef", 32'(s_undef), 1);
    rd_reg(0); chk("R9 base unchanged", s_rd, 32'h1000_0000);
    rd_reg(1); chk("R9 size unchanged", s_rd, 32'h0000_0023);
    rd_reg(3); chk("R9 index unchanged", s_rd, 0);
  endtask

  task automatic t_write_then_read();
    wr_reg(3, 3);
    wr_reg(0, 32'h3333_4000);
    chk("R5 flush after adjacent write", 32'(s_flush), 1);
    rd_reg(0);
    chk("R10 read right after write", s_rd, 32'h3333_4000);
    chk("R10 rd_valid right after write", 32'(s_rdv), 1);
    chk("R5 read cycle no flush", 32'(s_flush), 0);
    wr_reg(3, 0);
  endtask

  task automatic t_zero_regions();
    wr_reg(0, 32'h5555_5555);
    chk("R7 zero build no flush", 32'(s_zflush), 0);
    rd_reg(0);
    chk("R7 zero build base reads zero", s_zrd, 0);
    chk("R7 zero build read valid", 32'(s_zrdv), 1);
    wr_reg(3, 0);
    rd_reg(3);
    chk("R7 zero build index stays zero", s_zrd, 0);
    wr_reg(0, 32'h1000_0000);
  endtask

  task automatic t_mid_reset();
    wr_reg(3, 1);
    wr_reg(1, 32'h0000_0011);
    do_reset();
    rd_reg(3); chk("R4 index zero after second reset", s_rd, 0);
    wr_reg(3, 1);
    rd_reg(1); chk("R6 size zero after second reset", s_rd, 0);
    wr_reg(3, 3);
    rd_reg(0); chk("R6 base zero after second reset", s_rd, 0);
  endtask

  initial begin
    do_reset();
    @(negedge clk);
    t_reset_state();
    t_region_words();
    t_index_select();
    t_index_bounds();
    t_unpriv();
    t_unmatched();
    t_write_then_read();
    t_zero_regions();
    t_mid_reset();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule